// File: doc/BRIEF.md
# Bit-Serial by Parallel Unsigned Multiplier

This block multiplies two unsigned W-bit numbers with very little hardware. One operand is loaded as a whole word when a start strobe arrives. The other operand is then streamed in one bit per accepted cycle, least significant bit first. Each bit of the held word gates the stream through a single AND gate. The stream reaching gate j is delayed by j accepted cycles, so that gate's output stream carries the weight 2^j. A chain of W-1 bit-serial adders sums these streams. Each adder is one full adder whose carry is kept in a flip-flop and fed back as its carry-in on the next accepted cycle.

The caller presents 2W serial bits after each start. The block counts them and treats every bit after the first W as zero, so the upper half of the product is flushed out whatever the caller drives. Product bits leave the block least significant bit first, one registered cycle after the serial bit that produced them. A done pulse marks the last of the 2W product bits. A low valid input stalls the whole datapath without disturbing it. A new start clears all carry and delay state at any time, including in the middle of a product.

Top module: `bitser_mult`

## Requirements
- R1: After reset, prod_bit, prod_vld and done are all 0.
- R2: On a start cycle the block loads opnd_par. Changes on opnd_par after that cycle have no effect on the product until the next start.
- R3: The k-th accepted serial bit after a start (k = 0 .. 2W-1) causes prod_vld to be 1 in the next cycle, with prod_bit equal to bit k of the 2W-bit unsigned product. Bits come out least significant first. After the last bit, every carry and delay flip-flop holds 0.
- R4: Serial bits accepted at positions W .. 2W-1 are treated as 0, whatever value ser_bit has.
- R5: A cycle with ser_vld low is not accepted. prod_vld is 0 in the next cycle, and the carry and delay state is unchanged, so gaps in the stream do not alter the product.
- R6: done is 1 in exactly the cycle that carries product bit 2W-1, and always together with prod_vld. After that, ser_vld is ignored and gives no prod_vld until the next start.
- R7: start takes priority over ser_vld in the same cycle. It clears every carry and delay flip-flop, so a product started in the middle of an earlier one is still correct.
- R8: With W = 4, multiplying 1111 by 1111 gives the serial product 11100001 (0xE1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Loads the word operand and clears the serial state |
| ser_bit | input | 1 | Serial operand bit, least significant first |
| ser_vld | input | 1 | ser_bit is valid in this cycle |
| opnd_par | input | W | Word operand, loaded on start |
| prod_bit | output | 1 | Serial product bit, least significant first |
| prod_vld | output | 1 | prod_bit is valid |
| done | output | 1 | Marks product bit 2W-1 |

## Verification
The bench builds two copies of the block, one with W = 4 and one with W = 8. At W = 4 all 256 operand pairs are run, including 1111 by 1111. Some of these runs have gaps in the stream, random upper serial bits and extra valid bits after done. At W = 8 random pairs, the all-ones pair and zero operands reach carry chains eight stages deep and the longest flush. Aborted products, followed at once by a fresh start, show that the start strobe clears all carry and delay state.

// File: rtl/spm_pkg.sv
package spm_pkg;

  // Sum output of a full adder: odd parity of the three inputs.
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Carry output of a full adder: majority of the three inputs.
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (b & c) | (c & a);
  endfunction

  // Bit width of a counter that must reach the value n.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ser_vld,
  output logic accept,
  output logic last,
  output logic mask_hi,
  output logic busy
);
  import spm_pkg::*;

  localparam int NBITS = 2 * W;
  localparam int CW    = cnt_width(NBITS);

  logic [CW-1:0] cnt_q;

  assign accept  = busy & ser_vld & ~start;
  assign last    = (cnt_q == CW'(NBITS - 1));
  assign mask_hi = (cnt_q >= CW'(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      busy  <= 1'b1;
    end else if (accept) begin
      cnt_q <= cnt_q + CW'(1);
      if (last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/spm_dline.sv
module spm_dline #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic         x_in,
  output logic [W-1:0] taps,
  output logic [W-2:0] dly_q
);

  assign taps[0] = x_in;

  for (genvar j = 1; j < W; j++) begin : g_tap
    assign taps[j] = dly_q[j-1];
  end

  for (genvar j = 0; j < W - 1; j++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dly_q[j] <= 1'b0;
      else if (clr) dly_q[j] <= 1'b0;
      else if (adv) dly_q[j] <= taps[j];
    end
  end

endmodule

// File: rtl/spm_sadd.sv
module spm_sadd (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic a,
  input  logic b,
  output logic s,
  output logic carry_q
);
  import spm_pkg::*;

  logic cout;

  assign s    = fa_sum(a, b, carry_q);
  assign cout = fa_carry(a, b, carry_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   carry_q <= 1'b0;
    else if (clr) carry_q <= 1'b0;
    else if (adv) carry_q <= cout;
  end

endmodule

// File: rtl/bitser_mult.sv
module bitser_mult #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         ser_bit,
  input  logic         ser_vld,
  input  logic [W-1:0] opnd_par,
  output logic         prod_bit,
  output logic         prod_vld,
  output logic         done
);

  localparam int NADD = W - 1;

  logic            accept_w;
  logic            last_w;
  logic            mask_hi_w;
  logic            busy_w;
  logic            x_eff;
  logic [W-1:0]    opnd_q;
  logic [W-1:0]    taps;
  logic [W-1:0]    pp;
  logic [W-1:0]    chain;
  logic [NADD-1:0] dly_vec;
  logic [NADD-1:0] carry_vec;

  spm_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ser_vld (ser_vld),
    .accept  (accept_w),
    .last    (last_w),
    .mask_hi (mask_hi_w),
    .busy    (busy_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     opnd_q <= '0;
    else if (start) opnd_q <= opnd_par;
  end

  assign x_eff = ser_bit & ~mask_hi_w;

  spm_dline #(.W(W)) u_dline (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .adv   (accept_w),
    .x_in  (x_eff),
    .taps  (taps),
    .dly_q (dly_vec)
  );

  assign pp       = taps & opnd_q;
  assign chain[0] = pp[0];

  for (genvar j = 1; j < W; j++) begin : g_add
    spm_sadd u_sadd (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .adv     (accept_w),
      .a       (chain[j-1]),
      .b       (pp[j]),
      .s       (chain[j]),
      .carry_q (carry_vec[j-1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_bit <= 1'b0;
      prod_vld <= 1'b0;
      done     <= 1'b0;
    end else begin
      prod_vld <= accept_w;
      done     <= accept_w & last_w;
      if (accept_w) prod_bit <= chain[W-1];
    end
  end

endmodule

// File: rtl/spm_chk.sv
module spm_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ser_vld,
  input logic         prod_vld,
  input logic         done,
  input logic         busy_w,
  input logic [W-1:0] opnd_q,
  input logic [W-2:0] carry_vec,
  input logic [W-2:0] dly_vec
);

  p_opnd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !start) |=> $stable(opnd_q));

  p_flushed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (carry_vec == '0 && dly_vec == '0));

  p_stall_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_vld |=> !prod_vld);

  p_stall_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_vld && !start) |=> ($stable(carry_vec) && $stable(dly_vec)));

  p_done_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prod_vld);

  p_quiet_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !prod_vld);

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (carry_vec == '0 && dly_vec == '0 && !prod_vld && !done));

endmodule

bind bitser_mult spm_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ser_vld   (ser_vld),
  .prod_vld  (prod_vld),
  .done      (done),
  .busy_w    (busy_w),
  .opnd_q    (opnd_q),
  .carry_vec (carry_vec),
  .dly_vec   (dly_vec)
);

// File: tb/tb_bitser_mult.sv
`timescale 1ns/1ps

module tb_lane #(
  parameter int W = 4
) (
  input logic clk,
  input logic rst_n
);
  logic         start, ser_bit, ser_vld;
  logic [W-1:0] opnd;
  logic         prod_bit, prod_vld, done;

  bitser_mult #(.W(W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ser_bit  (ser_bit),
    .ser_vld  (ser_vld),
    .opnd_par (opnd),
    .prod_bit (prod_bit),
    .prod_vld (prod_vld),
    .done     (done)
  );

  bit             exp_q[$];
  bit             last_q[$];
  int             checks = 0;
  int             fails  = 0;
  int             extra  = 0;
  logic [2*W-1:0] acc = '0;
  logic [2*W-1:0] last_prod = '0;
  string          tag = "R3";

  initial begin
    start = 0; ser_bit = 0; ser_vld = 0; opnd = '0;
  end

  // Monitor: pops the scoreboard whenever a product bit is presented.
  always @(negedge clk) begin
    bit e, l;
    if (rst_n && prod_vld) begin
      if (exp_q.size() == 0) begin
        extra++;
      end else begin
        e = exp_q.pop_front();
        l = last_q.pop_front();
        checks++;
        if (prod_bit !== e) begin
          fails++;
          $display("FAIL %s/R2/R4/R5 W=%0d product bit: got %b expected %b", tag, W, prod_bit, e);
        end
        checks++;
        if (done !== l) begin
          fails++;
          $display("FAIL R6 W=%0d done flag: got %b expected %b", W, done, l);
        end
        acc = {prod_bit, acc[2*W-1:1]};
        if (l) last_prod = acc;
      end
    end
  end

  task automatic check_idle(input string t);
    checks++;
    if (prod_vld !== 1'b0 || done !== 1'b0 || prod_bit !== 1'b0) begin
      fails++;
      $display("FAIL %s W=%0d idle outputs: got %b%b%b expected 000", t, W, prod_vld, done, prod_bit);
    end
  endtask

  // Driver: one full product, pushing each expected bit as its serial bit is sent.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input bit gaps, input bit extra_bits, input string t);
    logic [2*W-1:0] p;
    int             x0;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    @(negedge clk);
    tag = t; start = 1; opnd = b; ser_vld = 0;
    @(negedge clk);
    start = 0; opnd = ~b;
    for (int k = 0; k < 2 * W; k++) begin
      if (gaps && (k % 3 == 1)) begin
        ser_vld = 0; ser_bit = 1'($urandom);
        @(negedge clk);
      end
      ser_vld = 1;
      ser_bit = (k < W) ? a[k] : 1'($urandom);
      exp_q.push_back(p[k]);
      last_q.push_back(k == 2 * W - 1);
      @(negedge clk);
    end
    ser_vld = 0;
    if (extra_bits) begin
      x0 = extra;
      ser_vld = 1; ser_bit = 1;
      @(negedge clk);
      @(negedge clk);
      ser_vld = 0;
      @(negedge clk);
      checks++;
      if (extra != x0) begin
        fails++;
        $display("FAIL R6 W=%0d output after done: got %0d expected 0", W, extra - x0);
      end
    end
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || extra != 0) begin
      fails++;
      $display("FAIL R3 W=%0d pending/unexpected bits: got %0d/%0d expected 0/0", W, exp_q.size(), extra);
      exp_q.delete(); last_q.delete(); extra = 0;
    end
  endtask

  // Partial product abandoned after nb bits; the next run restarts mid-way.
  task automatic abort(input logic [W-1:0] a, input logic [W-1:0] b, input int nb);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    @(negedge clk);
    tag = "R7"; start = 1; opnd = b; ser_vld = 0;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < nb; k++) begin
      ser_vld = 1; ser_bit = (k < W) ? a[k] : 1'b1;
      exp_q.push_back(p[k]);
      last_q.push_back(1'b0);
      @(negedge clk);
    end
    ser_vld = 0;
  endtask

endmodule

module tb_bitser_mult;
  logic clk = 0;
  logic rst_n = 0;
  int   wd_fail = 0;
  int   top_checks = 0;
  int   top_fails = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  tb_lane #(.W(4)) lane4 (.clk(clk), .rst_n(rst_n));
  tb_lane #(.W(8)) lane8 (.clk(clk), .rst_n(rst_n));

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed",
               lane4.checks + lane8.checks + top_checks + wd_fail,
               lane4.fails + lane8.fails + top_fails + wd_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    lane4.check_idle("R1");
    lane8.check_idle("R1");
    rst_n = 1;
    repeat (2) @(negedge clk);
    lane4.check_idle("R1");

    // R8: all-ones corner at W = 4
    lane4.run(4'hF, 4'hF, 1'b0, 1'b0, "R8");
    top_checks++;
    if (lane4.last_prod !== 8'hE1) begin
      top_fails++;
      $display("FAIL R8 1111x1111: got %b expected 11100001", lane4.last_prod);
    end

    // R3/R4/R5/R6: exhaustive at W = 4
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        lane4.run(4'(a), 4'(b), ((a + b) % 4) == 0, a == b, "R3");

    // R7: restart in the middle of a product
    lane4.abort(4'hF, 4'hF, 5);
    lane4.run(4'h9, 4'hB, 1'b0, 1'b0, "R7");
    lane8.abort(8'hFF, 8'hFF, 11);
    lane8.run(8'hA5, 8'h3C, 1'b1, 1'b0, "R7");

    // W = 8 corners and random pairs
    lane8.run(8'hFF, 8'hFF, 1'b0, 1'b1, "R3");
    lane8.run(8'h00, 8'hFF, 1'b1, 1'b0, "R3");
    lane8.run(8'hFF, 8'h00, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 150; i++)
      lane8.run(8'($urandom), 8'($urandom), (i % 5) == 0, (i % 7) == 0, "R3");

    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

endmodule